// File: doc/BRIEF.md
# Programming-Mode Memory Access Controller

This block serves the memory side of a 12-bit-word flash target while it sits in programming mode. A front end that has already decoded the serial protocol hands it one command at a time; the block keeps the address counter, holds the word to be programmed, returns read words, runs bulk erases and times the erase, programming and discharge intervals in clock cycles. The array itself is modelled as registers inside the block.

The 2K address space has two halves. The lower half holds 1024 user program words. The upper half holds four identification words, one backup calibration word and the configuration word; the configuration word can only be reached between mode entry and the first increment. The counter starts on the configuration word after mode entry, climbs straight from the end of user space into configuration space, and wraps from the top of the space back to zero.

Commands arrive on a valid/ready channel. Read results leave on a valid/ready channel with a single response slot. While a result waits unaccepted, `cmd_ready` is low and the result holds steady. When `rd_ready` is high, a new command can be taken in the same cycle the old result leaves. `mode_enter` is a plain pulse that takes priority over any command in the same cycle.

Top module: `progmem_ctl`

## Requirements
- R1: `cmd_op` codes are 0 read, 1 increment, 2 load, 3 begin-program, 4 end-program, 5 bulk erase. Codes 6 and 7 are accepted and then refused: `err_proto` pulses and nothing else changes.
- R2: After reset or a `mode_enter` pulse, the counter holds 0x7FF and a read there returns the configuration word. `mode_enter` also ends any timed interval and drops any held load word. Array contents are kept.
- R3: Each accepted increment adds one to the 11-bit counter. It moves from 0x3FF to 0x400, and from 0x7FF to 0x000.
- R4: After the first increment following entry, address 0x7FF reads as zero and is not writable until the next `mode_enter`.
- R5: Addresses 0x405–0x7FE, and 0x7FF once hidden, read as zero. A begin-program aimed at them is refused.
- R6: Stored words are 12 bits wide. A load keeps `cmd_data[11:0]` and ignores bits 13:12. Read data bits 13:12 are always zero.
- R7: Programming never erases. The stored word becomes the old word ANDed with the loaded word, and this takes effect when end-program is accepted.
- R8: A bulk erase with the counter at any address other than 0x400 sets every user word and the configuration word to 0xFFF. It leaves the identification words and the backup word unchanged.
- R9: A bulk erase with the counter at 0x400 sets all words, including the identification and backup words, to 0xFFF.
- R10: While configuration bit 4 is 0, reads of 0x040–0x3FE return zero. Reads of 0x000–0x03F, 0x3FF, 0x400–0x404 and the configuration word are never masked.
- R11: `busy` is high for exactly ERASE_CYC cycles after an erase. It stays high from begin-program until end-program is accepted, and end-program is accepted only after PROG_CYC cycles. It is then high for exactly DIS_CYC discharge cycles.
- R12: A command taken while `busy` is high is dropped and pulses `err_proto` one cycle later. The only exception is an end-program that is on time. An end-program while idle is dropped the same way.
- R13: A begin-program with no load since the previous begin-program (or since entry), or at a non-writable address, is ignored and pulses `err_seq`. The load word is consumed either way.
- R14: A read result stays valid with stable data until `rd_ready` is high, and no command is accepted while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; array reset to 0xFFF |
| mode_enter | input | 1 | Programming-mode entry pulse |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command ready |
| cmd_op | input | 3 | Command code (see R1) |
| cmd_data | input | 14 | Load data, lower 12 bits kept |
| busy | output | 1 | Timed interval in progress |
| err_proto | output | 1 | One-cycle pulse: command refused |
| err_seq | output | 1 | One-cycle pulse: begin-program refused |
| rd_valid | output | 1 | Read result valid |
| rd_ready | input | 1 | Read result accepted |
| rd_data | output | 14 | Read result, bits 13:12 zero |

## Verification
If the counter is wrong, the next read returns the wrong word. The bench places distinct words at 0x000, 0x400 and 0x404 so that a missed wrap or a wrong step at a region boundary appears at the next read. A wrong configuration-visibility or protection bit shows at the first read of 0x7FF or of 0x040. A wrong erase scope or a missing AND on programming can stay hidden until that address is read back, which may be thousands of cycles later, so every region is read after each erase. Timer faults appear directly as a wrong `busy` width, or as an on-time end-program being refused.

// File: rtl/progmem_pkg.sv
package progmem_pkg;
  localparam int ADDR_W     = 11;
  localparam int WORD_W     = 12;
  localparam int XFER_W     = 14;
  localparam int USER_DEPTH = 1 << (ADDR_W - 1);
  localparam int USER_AW    = $clog2(USER_DEPTH);
  localparam int ID_COUNT   = 4;
  localparam int ID_AW      = $clog2(ID_COUNT);
  localparam int CP_BIT     = 4;

  localparam logic [ADDR_W-1:0] A_ID_BASE = 11'h400;
  localparam logic [ADDR_W-1:0] A_BACKUP  = 11'h404;
  localparam logic [ADDR_W-1:0] A_CFG     = 11'h7FF;
  localparam logic [ADDR_W-1:0] A_PROT_LO = 11'h040;
  localparam logic [ADDR_W-1:0] A_PROT_HI = 11'h3FE;

  typedef logic [2:0] op_t;
  localparam op_t OP_READ  = 3'd0;
  localparam op_t OP_INC   = 3'd1;
  localparam op_t OP_LOAD  = 3'd2;
  localparam op_t OP_BEGIN = 3'd3;
  localparam op_t OP_END   = 3'd4;
  localparam op_t OP_ERASE = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_ERASE, ST_PROG, ST_DISCH} seq_state_t;
  typedef enum logic [2:0] {RG_USER, RG_ID, RG_BACKUP, RG_CFG, RG_NONE} region_t;
endpackage

// File: rtl/progmem_addr.sv
module progmem_addr
  import progmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter,
  input  logic              inc,
  output logic [ADDR_W-1:0] pc,
  output logic              cfg_vis
);
  always_ff @(posedge clk) begin
    if (!rst_n || enter) begin
      pc      <= A_CFG;
      cfg_vis <= 1'b1;
    end else if (inc) begin
      pc      <= pc + 1'b1;
      cfg_vis <= 1'b0;
    end
  end
endmodule

// File: rtl/progmem_array.sv
module progmem_array
  import progmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pc,
  input  logic              cfg_vis,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              erase_en,
  input  logic              erase_all,
  output region_t           region,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] user_mem [USER_DEPTH];
  logic [WORD_W-1:0] id_mem   [ID_COUNT];
  logic [WORD_W-1:0] backup_q;
  logic [WORD_W-1:0] cfg_q;
  logic [WORD_W-1:0] raw;
  logic              masked;

  always_comb begin
    if (!pc[ADDR_W-1])                                region = RG_USER;
    else if (pc[ADDR_W-1:ID_AW] == A_ID_BASE[ADDR_W-1:ID_AW]) region = RG_ID;
    else if (pc == A_BACKUP)                          region = RG_BACKUP;
    else if (pc == A_CFG && cfg_vis)                  region = RG_CFG;
    else                                              region = RG_NONE;
  end

  always_comb begin
    unique case (region)
      RG_USER:   raw = user_mem[pc[USER_AW-1:0]];
      RG_ID:     raw = id_mem[pc[ID_AW-1:0]];
      RG_BACKUP: raw = backup_q;
      RG_CFG:    raw = cfg_q;
      default:   raw = '0;
    endcase
  end

  assign masked  = !cfg_q[CP_BIT] && (pc >= A_PROT_LO) && (pc <= A_PROT_HI);
  assign rd_word = masked ? '0 : raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < USER_DEPTH; i++) user_mem[i] <= '1;
      for (int j = 0; j < ID_COUNT; j++)   id_mem[j]   <= '1;
      backup_q <= '1;
      cfg_q    <= '1;
    end else if (erase_en) begin
      for (int i = 0; i < USER_DEPTH; i++) user_mem[i] <= '1;
      cfg_q <= '1;
      if (erase_all) begin
        for (int j = 0; j < ID_COUNT; j++) id_mem[j] <= '1;
        backup_q <= '1;
      end
    end else if (wr_en) begin
      unique case (region)
        RG_USER:   user_mem[pc[USER_AW-1:0]] <= user_mem[pc[USER_AW-1:0]] & wr_word;
        RG_ID:     id_mem[pc[ID_AW-1:0]]     <= id_mem[pc[ID_AW-1:0]] & wr_word;
        RG_BACKUP: backup_q <= backup_q & wr_word;
        RG_CFG:    cfg_q    <= cfg_q & wr_word;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/progmem_seq.sv
module progmem_seq
  import progmem_pkg::*;
#(
  parameter int ERASE_CYC = 48,
  parameter int PROG_CYC  = 16,
  parameter int DIS_CYC   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  op_t               cmd_op,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [XFER_W-1:0] rd_data,
  input  region_t           region,
  input  logic              at_id_base,
  input  logic [WORD_W-1:0] rd_word,
  output logic              busy,
  output logic              err_proto,
  output logic              err_seq,
  output logic              inc_en,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_word,
  output logic              erase_en,
  output logic              erase_all
);
  localparam int MAX_A = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int MAX_C = (MAX_A > DIS_CYC) ? MAX_A : DIS_CYC;
  localparam int TW    = $clog2(MAX_C + 1);

  seq_state_t        state;
  logic [TW-1:0]     timer;
  logic              loaded;
  logic              fire, idle_ok, end_ok, begin_try, begin_ok;

  assign cmd_ready = !rd_valid || rd_ready;
  assign busy      = (state != ST_IDLE);
  assign fire      = cmd_valid && cmd_ready && !enter;
  assign idle_ok   = fire && !busy && (cmd_op <= OP_ERASE) && (cmd_op != OP_END);
  assign end_ok    = fire && state == ST_PROG && cmd_op == OP_END && timer == '0;
  assign begin_try = idle_ok && cmd_op == OP_BEGIN;
  assign begin_ok  = begin_try && loaded && region != RG_NONE;
  assign inc_en    = idle_ok && cmd_op == OP_INC;
  assign erase_en  = idle_ok && cmd_op == OP_ERASE;
  assign erase_all = at_id_base;
  assign wr_en     = end_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      timer     <= '0;
      loaded    <= 1'b0;
      wr_word   <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      err_proto <= 1'b0;
      err_seq   <= 1'b0;
    end else begin
      err_proto <= fire && !idle_ok && !end_ok;
      err_seq   <= begin_try && !begin_ok;
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      if (enter) begin
        state    <= ST_IDLE;
        timer    <= '0;
        loaded   <= 1'b0;
        rd_valid <= 1'b0;
      end else begin
        if (idle_ok) begin
          unique case (cmd_op)
            OP_READ: begin
              rd_valid <= 1'b1;
              rd_data  <= {{(XFER_W-WORD_W){1'b0}}, rd_word};
            end
            OP_LOAD: begin
              wr_word <= cmd_word;
              loaded  <= 1'b1;
            end
            OP_BEGIN: begin
              loaded <= 1'b0;
              if (begin_ok) begin
                state <= ST_PROG;
                timer <= TW'(PROG_CYC - 1);
              end
            end
            OP_ERASE: begin
              state <= ST_ERASE;
              timer <= TW'(ERASE_CYC - 1);
            end
            default: ;
          endcase
        end
        unique case (state)
          ST_ERASE, ST_DISCH: begin
            if (timer == '0) state <= ST_IDLE;
            else             timer <= timer - 1'b1;
          end
          ST_PROG: begin
            if (end_ok) begin
              state <= ST_DISCH;
              timer <= TW'(DIS_CYC - 1);
            end else if (timer != '0) begin
              timer <= timer - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/progmem_ctl.sv
module progmem_ctl
  import progmem_pkg::*;
#(
  parameter int ERASE_CYC = 48,
  parameter int PROG_CYC  = 16,
  parameter int DIS_CYC   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_enter,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [2:0]  cmd_op,
  input  logic [13:0] cmd_data,
  output logic        busy,
  output logic        err_proto,
  output logic        err_seq,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [13:0] rd_data
);
  logic [ADDR_W-1:0] pc_q;
  logic              cfg_vis_q;
  logic              inc_en, wr_en, erase_en, erase_all;
  logic [WORD_W-1:0] wr_word, rd_word;
  region_t           region;
  logic              unused_hi;

  assign unused_hi = ^cmd_data[XFER_W-1:WORD_W];

  progmem_addr u_addr (
    .clk(clk), .rst_n(rst_n), .enter(mode_enter), .inc(inc_en),
    .pc(pc_q), .cfg_vis(cfg_vis_q)
  );

  progmem_array u_array (
    .clk(clk), .rst_n(rst_n), .pc(pc_q), .cfg_vis(cfg_vis_q),
    .wr_en(wr_en), .wr_word(wr_word), .erase_en(erase_en),
    .erase_all(erase_all), .region(region), .rd_word(rd_word)
  );

  progmem_seq #(
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .DIS_CYC(DIS_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .enter(mode_enter),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_word(cmd_data[WORD_W-1:0]), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .region(region),
    .at_id_base(pc_q == A_ID_BASE), .rd_word(rd_word), .busy(busy),
    .err_proto(err_proto), .err_seq(err_seq), .inc_en(inc_en),
    .wr_en(wr_en), .wr_word(wr_word), .erase_en(erase_en),
    .erase_all(erase_all)
  );
endmodule

// File: rtl/progmem_ctl_chk.sv
module progmem_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_enter,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [2:0]  cmd_op,
  input logic        busy,
  input logic        err_proto,
  input logic        err_seq,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [13:0] rd_data,
  input logic [10:0] pc,
  input logic        cfg_vis
);
  logic take;
  assign take = cmd_valid && cmd_ready && !mode_enter;

  AST_ENTER_AT_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    mode_enter |=> (pc == 11'h7FF && cfg_vis)); // R2
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !busy && cmd_op == 3'd1) |=> pc == $past(pc) + 11'd1); // R3
  AST_CFG_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !busy && cmd_op == 3'd1) |=> !cfg_vis); // R4
  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && busy && cmd_op != 3'd4) |=> err_proto); // R12
  AST_BUSY_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && busy && !mode_enter) |=> $stable(pc)); // R12
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !mode_enter) |=> (rd_valid && $stable(rd_data))); // R14
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_proto && err_seq)); // R13
endmodule

bind progmem_ctl progmem_ctl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .mode_enter(mode_enter), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_op(cmd_op), .busy(busy), .err_proto(err_proto),
  .err_seq(err_seq), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .pc(pc_q), .cfg_vis(cfg_vis_q)
);

// File: tb/test_progmem_ctl.sv
module test_progmem_ctl;
  localparam int ERASE_CYC = 48;
  localparam int PROG_CYC  = 16;
  localparam int DIS_CYC   = 8;
  localparam logic [2:0] RD = 3'd0, INC = 3'd1, LD = 3'd2, BG = 3'd3, EN = 3'd4, ER = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [13:0] data;
    logic        chk;
    logic [13:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{RD,  14'h0000, 1'b1, 14'h0FFF},  // R2 config word after reset
    '{LD,  14'h3FEF, 1'b0, 14'h0000},  // R6 high bits dropped
    '{BG,  14'h0000, 1'b0, 14'h0000},
    '{EN,  14'h0000, 1'b0, 14'h0000},
    '{RD,  14'h0000, 1'b1, 14'h0FEF},  // R7 config programmed, bit 4 now 0
    '{INC, 14'h0000, 1'b0, 14'h0000},
    '{RD,  14'h0000, 1'b1, 14'h0FFF},  // R10 0x000 never masked
    '{LD,  14'h2A5C, 1'b0, 14'h0000},
    '{BG,  14'h0000, 1'b0, 14'h0000},
    '{EN,  14'h0000, 1'b0, 14'h0000},
    '{RD,  14'h0000, 1'b1, 14'h0A5C},  // R6 stored 12 bits, read top zero
    '{LD,  14'h0F0F, 1'b0, 14'h0000},
    '{BG,  14'h0000, 1'b0, 14'h0000},
    '{EN,  14'h0000, 1'b0, 14'h0000},
    '{RD,  14'h0000, 1'b1, 14'h0A0C}   // R7 AND with old word
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_enter = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = 3'd0;
  logic [13:0] cmd_data = '0;
  logic        busy, err_proto, err_seq, rd_valid;
  logic        rd_ready = 1'b1;
  logic [13:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic        s_rv, s_ep, s_es, s_busy;
  logic [13:0] s_rd;

  always #5 clk = ~clk;

  progmem_ctl #(.ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .DIS_CYC(DIS_CYC)) i_progmem_ctl (
    .clk(clk), .rst_n(rst_n), .mode_enter(mode_enter), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data), .busy(busy),
    .err_proto(err_proto), .err_seq(err_seq), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [13:0] d);
    @(negedge clk);
    cmd_op = op; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    s_rv = rd_valid; s_rd = rd_data; s_ep = err_proto; s_es = err_seq; s_busy = busy;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic rd_expect(input string req, input logic [13:0] exp);
    issue(RD, '0);
    chk(req, {s_rv, s_ep, 2'b00, s_rd}, {1'b1, 1'b0, 2'b00, exp});
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) issue(INC, '0);
  endtask

  task automatic program_word(input logic [13:0] d);
    issue(LD, d);
    issue(BG, '0);
    repeat (PROG_CYC + 1) @(negedge clk);
    issue(EN, '0);
    wait_idle();
  endtask

  task automatic enter_mode();
    @(negedge clk); mode_enter = 1'b1;
    @(negedge clk); mode_enter = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state at the ports
    chk("R2 reset outputs", {busy, rd_valid, err_proto, err_seq, cmd_ready}, {4'b0000, 1'b1});

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].op == EN) repeat (PROG_CYC + 1) @(negedge clk);
      else wait_idle();
      issue(VECS[v].op, VECS[v].data);
      chk($sformatf("R1 vec %0d no error", v), {s_ep, s_es}, 2'b00);
      if (VECS[v].chk)
        chk($sformatf("R6 R7 vec %0d read", v), {s_rv, s_rd}, {1'b1, VECS[v].exp});
    end
    wait_idle();

    // R1 undefined code refused, no effect
    issue(3'd7, '0);
    chk("R1 code 7 err_proto", {s_ep, s_es, s_rv}, 3'b100);
    rd_expect("R1 no effect", 14'h0A0C);
    issue(EN, '0);
    chk("R12 end while idle", s_ep, 1'b1);

    // R10 protection window edges
    step(63);
    rd_expect("R10 0x03F open", 14'h0FFF);
    step(1);
    rd_expect("R10 0x040 masked", 14'h0000);
    step(12'h3FF - 12'h040);
    rd_expect("R10 0x3FF open", 14'h0FFF);
    step(1);
    rd_expect("R3 0x3FF to 0x400", 14'h0FFF);
    program_word(14'h0123);
    rd_expect("R10 id readable", 14'h0123);

    // R13 begin without load
    issue(BG, '0);
    chk("R13 no load err_seq", {s_es, s_ep, s_busy}, 3'b100);
    rd_expect("R13 word unchanged", 14'h0123);

    // backup word with early end, R11 and R12
    step(4);
    issue(LD, 14'h0055);
    issue(BG, '0);
    issue(EN, '0);
    chk("R11 early end refused", {s_ep, s_busy}, 2'b11);
    repeat (PROG_CYC) @(negedge clk);
    chk("R11 busy while programming", busy, 1'b1);
    issue(EN, '0);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R11 discharge length", n, DIS_CYC);
    rd_expect("R7 backup programmed", 14'h0055);

    // R5 reserved address
    step(1);
    rd_expect("R5 0x405 reads zero", 14'h0000);
    issue(LD, 14'h0000);
    issue(BG, '0);
    chk("R5 R13 begin at reserved", {s_es, s_busy}, 2'b10);

    // R2 re-entry, R8 scoped erase
    enter_mode();
    rd_expect("R2 R4 config visible again", 14'h0FEF);
    issue(ER, '0);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R11 erase length", n, ERASE_CYC);
    rd_expect("R8 config erased", 14'h0FFF);
    step(1);
    rd_expect("R8 user erased", 14'h0FFF);
    program_word(14'h0321);
    rd_expect("R7 word at 0x000", 14'h0321);
    step(12'h400);
    rd_expect("R8 id kept", 14'h0123);
    step(4);
    rd_expect("R8 backup kept", 14'h0055);
    step(12'h7FF - 12'h404);
    rd_expect("R4 config hidden", 14'h0000);
    issue(LD, 14'h0000);
    issue(BG, '0);
    chk("R4 hidden config not writable", s_es, 1'b1);
    step(1);
    rd_expect("R3 wrap to 0x000", 14'h0321);

    // R9 full erase at 0x400, R12 refusal during erase
    enter_mode();
    step(12'h401);
    issue(ER, '0);
    issue(INC, '0);
    chk("R12 inc during erase", {s_ep, s_busy}, 2'b11);
    issue(RD, '0);
    chk("R12 read during erase", {s_ep, s_rv}, 2'b10);
    wait_idle();
    rd_expect("R9 id erased", 14'h0FFF);
    step(4);
    rd_expect("R9 R12 backup erased", 14'h0FFF);

    // R14 back-pressure on read results
    @(negedge clk); rd_ready = 1'b0;
    issue(RD, '0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R14 held result", {rd_valid, cmd_ready, rd_data}, {1'b1, 1'b0, 14'h0FFF});
    end
    rd_ready = 1'b1;
    @(negedge clk);
    chk("R14 released", {rd_valid, cmd_ready}, 2'b01);

    done = 1'b1;
    finish_run();
  end
endmodule